// File: doc/BRIEF.md
# Two-Thread Alternating Allocator with Mode Control

This block decides, every cycle, which of two hardware threads may use a shared pipeline stage. For each thread it receives two flags: whether that thread's input queue holds work, and whether that thread's downstream buffers are full. A thread can be picked only when it has work and room downstream.

When both threads can go, the grant alternates between them from one cycle to the next. When only one can go, that thread is granted even if it is not its turn, so a lone thread gets the stage's whole bandwidth. The grant is combinational from the current flags and the registered turn and mode state.

A small state machine tracks the processor mode. The modes are both threads running, only thread 0 running, only thread 1 running, and a low-power state with neither running. Per-thread halt and interrupt inputs move it between these modes. From the mode, the block derives a per-thread entry limit for partitioned buffers. With both threads running, each thread gets half of the entries. With one thread running, that thread gets all of them.

Top module: `thread_alloc_arbiter`

## Requirements
- R1: After reset the mode is both-threads (code 0), thread 0 holds the turn, and `grant` is 0 while no thread has work.
- R2: `grant` is zero or one-hot (bit 0 is thread 0, bit 1 is thread 1). A thread is granted only when it is running, `q_nonempty` is 1 and `buf_full` is 0 for that thread.
- R3: When both threads are eligible, the grant alternates on successive eligible cycles, starting with thread 0 after reset. The turn changes only on cycles where both were eligible.
- R4: When exactly one thread is eligible, it is granted in that same cycle, whatever the turn.
- R5: `mode` uses four codes: 0 = both threads, 1 = only thread 0, 2 = only thread 1, 3 = low power. In mode 0, the next mode is set as follows:
  - A halt from thread 0 alone moves to mode 2.
  - A halt from thread 1 alone moves to mode 1.
  - Halts from both threads at once move to mode 3.
  - Interrupts are ignored in mode 0.
- R6: In mode 1 or 2, an interrupt to the halted thread moves to mode 0 on the next cycle, and this wins over a same-cycle halt. Otherwise, a halt from the running thread moves to mode 3. The halt of the stopped thread and the interrupt of the running thread are ignored.
- R7: In mode 3, an interrupt to thread N alone moves to the mode where only thread N runs (1 or 2). Interrupts to both threads move to mode 0. Halts are ignored.
- R8: A thread that is halted (not running in the current mode) is never granted, whatever its queue and buffer flags.
- R9: The entry limits follow the current mode: DEPTH/2 for each thread in mode 0; DEPTH for the running thread and 0 for the other in modes 1 and 2; 0 for both in mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | 2 | Per-thread input queue holds work |
| buf_full | input | 2 | Per-thread downstream buffers full |
| halt_req | input | 2 | Per-thread halt request |
| intr_req | input | 2 | Per-thread interrupt |
| grant | output | 2 | One-hot grant for this cycle |
| mode | output | 2 | Current mode code |
| lim_t0 | output | $clog2(DEPTH+1) | Entry limit for thread 0 |
| lim_t1 | output | $clog2(DEPTH+1) | Entry limit for thread 1 |

## Verification
`grant`, `lim_t0` and `lim_t1` are due in the same cycle as the flags and the mode that produce them. A new mode or a flipped turn shows up only one rising edge after the halt, interrupt or both-eligible cycle that caused it. The bench drives every input at the falling edge and samples the outputs two nanoseconds before the next rising edge. Its behavioural model advances its own mode and turn at that same edge, so each comparison sees exactly one register update per stimulus cycle.

// File: rtl/thread_alloc_pkg.sv
package thread_alloc_pkg;

    typedef enum logic [1:0] {
        MODE_BOTH  = 2'd0,
        MODE_ONLY0 = 2'd1,
        MODE_ONLY1 = 2'd2,
        MODE_SLEEP = 2'd3
    } run_mode_e;

    typedef struct packed {
        run_mode_e mode;
    } fsm_state_t;

    typedef struct packed {
        logic turn;
    } arb_state_t;

    localparam int NUM_THREADS = 2;

endpackage

// File: rtl/thread_mode_fsm.sv
module thread_mode_fsm
    import thread_alloc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] halt_req,
    input  logic [NUM_THREADS-1:0] intr_req,
    output run_mode_e              mode,
    output logic [NUM_THREADS-1:0] running
);

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_BOTH: begin
                if (halt_req[0] && halt_req[1]) begin
                    st_d.mode = MODE_SLEEP;
                end else if (halt_req[0]) begin
                    st_d.mode = MODE_ONLY1;
                end else if (halt_req[1]) begin
                    st_d.mode = MODE_ONLY0;
                end
            end
            MODE_ONLY0: begin
                if (intr_req[1]) begin
                    st_d.mode = MODE_BOTH;
                end else if (halt_req[0]) begin
                    st_d.mode = MODE_SLEEP;
                end
            end
            MODE_ONLY1: begin
                if (intr_req[0]) begin
                    st_d.mode = MODE_BOTH;
                end else if (halt_req[1]) begin
                    st_d.mode = MODE_SLEEP;
                end
            end
            MODE_SLEEP: begin
                if (intr_req[0] && intr_req[1]) begin
                    st_d.mode = MODE_BOTH;
                end else if (intr_req[0]) begin
                    st_d.mode = MODE_ONLY0;
                end else if (intr_req[1]) begin
                    st_d.mode = MODE_ONLY1;
                end
            end
            default: st_d.mode = MODE_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_BOTH};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode       = st_q.mode;
    assign running[0] = (st_q.mode == MODE_BOTH) || (st_q.mode == MODE_ONLY0);
    assign running[1] = (st_q.mode == MODE_BOTH) || (st_q.mode == MODE_ONLY1);

endmodule

// File: rtl/turn_arbiter.sv
module turn_arbiter
    import thread_alloc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] eligible,
    output logic [NUM_THREADS-1:0] grant
);

    arb_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        grant = '0;
        unique case (eligible)
            2'b11: begin
                grant[st_q.turn] = 1'b1;
                st_d.turn        = ~st_q.turn;
            end
            2'b01:   grant = 2'b01;
            2'b10:   grant = 2'b10;
            default: grant = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{turn: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/entry_limit_gen.sv
module entry_limit_gen
    import thread_alloc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  run_mode_e                       mode,
    output logic [NUM_THREADS-1:0][LW-1:0]  limit
);

    localparam logic [LW-1:0] FULL_LIM = LW'(DEPTH);
    localparam logic [LW-1:0] HALF_LIM = LW'(DEPTH / 2);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        localparam run_mode_e SOLO = (t == 0) ? MODE_ONLY0 : MODE_ONLY1;
        always_comb begin
            if (mode == MODE_BOTH) begin
                limit[t] = HALF_LIM;
            end else if (mode == SOLO) begin
                limit[t] = FULL_LIM;
            end else begin
                limit[t] = '0;
            end
        end
    end

endmodule

// File: rtl/thread_alloc_arbiter.sv
module thread_alloc_arbiter
    import thread_alloc_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    q_nonempty,
    input  logic [1:0]    buf_full,
    input  logic [1:0]    halt_req,
    input  logic [1:0]    intr_req,
    output logic [1:0]    grant,
    output logic [1:0]    mode,
    output logic [LW-1:0] lim_t0,
    output logic [LW-1:0] lim_t1
);

    run_mode_e                      mode_w;
    logic [NUM_THREADS-1:0]         running;
    logic [NUM_THREADS-1:0]         eligible;
    logic [NUM_THREADS-1:0][LW-1:0] limit;

    thread_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .intr_req (intr_req),
        .mode     (mode_w),
        .running  (running)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_elig
        assign eligible[t] = running[t] && q_nonempty[t] && !buf_full[t];
    end

    turn_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .grant    (grant)
    );

    entry_limit_gen #(.DEPTH(DEPTH), .LW(LW)) u_lim (
        .mode  (mode_w),
        .limit (limit)
    );

    assign mode   = mode_w;
    assign lim_t0 = limit[0];
    assign lim_t1 = limit[1];

endmodule

// File: rtl/thread_alloc_chk.sv
module thread_alloc_chk #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    q_nonempty,
    input logic [1:0]    buf_full,
    input logic [1:0]    halt_req,
    input logic [1:0]    intr_req,
    input logic [1:0]    grant,
    input logic [1:0]    mode,
    input logic [LW-1:0] lim_t0,
    input logic [LW-1:0] lim_t1
);

    logic       seen;
    logic [1:0] run_c;
    logic [1:0] ok_c;

    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assign run_c[0] = (mode == 2'd0) || (mode == 2'd1);
    assign run_c[1] = (mode == 2'd0) || (mode == 2'd2);
    assign ok_c     = run_c & q_nonempty & ~buf_full;

    // R2
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2 / R8
    a_r8_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~ok_c) == 2'b00);
    // R3
    a_r3_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && ok_c == 2'b11 && $past(ok_c) == 2'b11) |-> grant != $past(grant));
    // R4
    a_r4_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_c == 2'b01 || ok_c == 2'b10) |-> grant == ok_c);
    // R5
    a_r5_halt0: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && halt_req == 2'b01) |=> mode == 2'd2);
    // R6
    a_r6_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && intr_req[1]) |=> mode == 2'd0);
    // R7
    a_r7_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && intr_req == 2'b10) |=> mode == 2'd2);
    // R9
    a_r9_split: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (lim_t0 == LW'(DEPTH / 2) && lim_t1 == LW'(DEPTH / 2)));
    // R9
    a_r9_total: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, lim_t0} + {1'b0, lim_t1}) <= (LW + 1)'(DEPTH));

endmodule

bind thread_alloc_arbiter thread_alloc_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_nonempty (q_nonempty),
    .buf_full   (buf_full),
    .halt_req   (halt_req),
    .intr_req   (intr_req),
    .grant      (grant),
    .mode       (mode),
    .lim_t0     (lim_t0),
    .lim_t1     (lim_t1)
);

// File: tb/sim_thread_alloc_arbiter.sv
`timescale 1ns/1ps
module sim_thread_alloc_arbiter;

    localparam int DEPTH = 32;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    q_nonempty = '0, buf_full = '0, halt_req = '0, intr_req = '0;
    logic [1:0]    grant, mode;
    logic [LW-1:0] lim_t0, lim_t1;

    int total = 0;
    int bad   = 0;
    int m_mode = 0;
    int m_turn = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    thread_alloc_arbiter #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .buf_full(buf_full),
        .halt_req(halt_req), .intr_req(intr_req), .grant(grant), .mode(mode),
        .lim_t0(lim_t0), .lim_t1(lim_t1)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int lim_exp(input int md, input int t);
        if (md == 0) return DEPTH / 2;
        if (md == 3) return 0;
        return ((md == 1 && t == 0) || (md == 2 && t == 1)) ? DEPTH : 0;
    endfunction

    // one cycle: drive at falling edge, compare before rising edge, advance model
    task automatic step(input logic [1:0] qn, input logic [1:0] bf,
                        input logic [1:0] hl, input logic [1:0] ir);
        bit r0, r1, e0, e1;
        int eg;
        @(negedge clk);
        q_nonempty = qn; buf_full = bf; halt_req = hl; intr_req = ir;
        #2;
        r0 = (m_mode == 0 || m_mode == 1);
        r1 = (m_mode == 0 || m_mode == 2);
        e0 = r0 && qn[0] && !bf[0];
        e1 = r1 && qn[1] && !bf[1];
        if (e0 && e1) eg = (m_turn == 0) ? 1 : 2;
        else if (e0)  eg = 1;
        else if (e1)  eg = 2;
        else          eg = 0;
        if (e0 && e1)                check("R3 alternate grant", int'(grant), eg);
        else if (e0 || e1)           check("R4 single eligible grant", int'(grant), eg);
        else if (qn != 0 && !(r0 && r1)) check("R8 halted thread not granted", int'(grant), eg);
        else                         check("R2 no eligible thread", int'(grant), eg);
        check("R5 mode code", int'(mode), m_mode);
        check("R9 limit t0", int'(lim_t0), lim_exp(m_mode, 0));
        check("R9 limit t1", int'(lim_t1), lim_exp(m_mode, 1));
        if (e0 && e1) m_turn = 1 - m_turn;
        case (m_mode)
            0: if (hl == 2'b11) m_mode = 3; else if (hl[0]) m_mode = 2; else if (hl[1]) m_mode = 1;
            1: if (ir[1]) m_mode = 0; else if (hl[0]) m_mode = 3;
            2: if (ir[0]) m_mode = 0; else if (hl[1]) m_mode = 3;
            default: if (ir == 2'b11) m_mode = 0; else if (ir[0]) m_mode = 1; else if (ir[1]) m_mode = 2;
        endcase
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1 reset mode", int'(mode), 0);
        check("R1 reset grant", int'(grant), 0);
        // R3: both eligible, thread 0 first then alternate
        for (int k = 0; k < 5; k++) step(2'b11, 2'b00, 2'b00, 2'b00);
        // R3: turn kept across single-eligible cycles; R4 fall-through
        step(2'b10, 2'b00, 2'b00, 2'b00);
        step(2'b10, 2'b00, 2'b00, 2'b00);
        step(2'b11, 2'b01, 2'b00, 2'b00);
        step(2'b11, 2'b00, 2'b00, 2'b00);
        step(2'b11, 2'b11, 2'b00, 2'b00);
        // R5: interrupts ignored in both-threads mode, then halt thread 0
        step(2'b11, 2'b00, 2'b00, 2'b11);
        step(2'b11, 2'b00, 2'b01, 2'b00);
        // R8: thread 0 halted, thread 1 owns the stage
        for (int k = 0; k < 3; k++) step(2'b11, 2'b00, 2'b00, 2'b10);
        // R6: stopped thread's halt ignored, then running thread halts
        step(2'b11, 2'b00, 2'b01, 2'b00);
        step(2'b11, 2'b00, 2'b10, 2'b00);
        // R7: halts ignored in low power, interrupt thread 0
        step(2'b11, 2'b00, 2'b11, 2'b00);
        step(2'b11, 2'b00, 2'b00, 2'b01);
        // R6: interrupt to halted thread wins over halt
        step(2'b11, 2'b00, 2'b01, 2'b10);
        step(2'b11, 2'b00, 2'b00, 2'b00);
        // R5: both halt together -> low power; R7 both interrupts -> both
        step(2'b11, 2'b00, 2'b11, 2'b00);
        step(2'b11, 2'b00, 2'b00, 2'b11);
        step(2'b11, 2'b00, 2'b10, 2'b00);
        step(2'b11, 2'b00, 2'b01, 2'b00);
        step(2'b11, 2'b00, 2'b00, 2'b10);
        step(2'b11, 2'b00, 2'b00, 2'b00);
        // mixed pseudo-random traffic
        for (int k = 0; k < 3000; k++) begin
            logic [1:0] hl, ir;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            hl = (lfsr[7:5] == 3'b111) ? lfsr[9:8] : 2'b00;
            ir = (lfsr[12:10] == 3'b101) ? lfsr[14:13] : 2'b00;
            step(lfsr[1:0] | {lfsr[4], 1'b0}, lfsr[3:2] & {lfsr[15], lfsr[15]}, hl, ir);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule